// File: doc/BRIEF.md
# Memory Controller Configuration and Mode-Register Loader

This block sits at the command edge of a double-data-rate memory controller. It takes the 3-bit user command and the address bus. From the two configuration commands it maintains four 20-bit configuration registers, and it fans their timing fields out as registered outputs to the rest of the controller.

The burst length, burst type and CAS latency live in two places: configuration register 0 and the memory's mode register. This block keeps the two copies in agreement. Loading register 0 issues a mode-register-set request carrying the new settings. Writing the memory mode register directly copies the same three fields back into register 0.

Each mode-register-set request is a single-cycle pulse with a bank select and a 12-bit value. After the pulse, the block holds `busy` for the programmed tMRD wait before it accepts another command. Setting the init bit in register 0 emits a one-cycle start pulse for the power-up sequencer. `busy` then stays high until that sequencer reports completion.

Top module: `cfg_mode_loader`

## Requirements
- R1: After reset, register 0 holds burst length code 001, sequential burst (0) and CAS code 010. The other reset values are: tRCD 2, tRRD 2, tRFC 9, tRP 2, tMRD 2, tWR 2, refresh interval 2228, tRAS 6, tWTR 1 and tRC 8. After reset, `busy`, `mrs_req`, `init_start`, `drive_reduced` and `qfc_enable` are all 0.
- R2: Command 011 loads the register chosen by addr[1:0], using addr[21:2] as register bits [19:0]. The field layout is as follows. Register 1: tRCD [2:0], tRRD [5:3], tRFC [9:6], tRP [12:10], tMRD [15:13], tWR [18:16]. Register 2: refresh interval [15:0]. Register 3: tRAS [3:0], tWTR [6:4], tRC [10:7]. Each new field value appears on its output port in the cycle after the command is sampled.
- R3: Loading register 1, 2 or 3 issues no mode-register request and does not raise `busy`. Register bits outside the named fields are discarded.
- R4: A load of register 0 updates three fields: burst length from data bits [2:0], burst type from bit [3] (1 = interleaved) and CAS latency code from bits [6:4]. In the cycle after the command, `mrs_req` is 1 with bank 00. The request value has the register 0 data bits [6:0] in value bits [6:0]. Value bits [11:7] are taken from the last direct mode-register write, or are 0 since reset.
- R5: A register 0 load with data bit 7 set gives a one-cycle `init_start` pulse in the cycle after the command. `busy` then stays high until `init_done` is sampled high, and falls in the cycle after that.
- R6: Command 100 with addr[13:12] = 00 writes the mode register with addr[11:0]. It raises `mrs_req` with bank 00 and that value. It also copies addr[2:0], addr[3] and addr[6:4] into burst length, burst type and CAS latency.
- R7: Command 100 with addr[13:12] = 01 writes the extended mode register with addr[11:0] and raises `mrs_req` with bank 01. Bit 1 of that value sets `drive_reduced`, and bit 2 sets `qfc_enable`.
- R8: Command 100 with addr[13:12] = 10 or 11 has no effect: no request, no `busy`, and no field change.
- R9: `mrs_req` is high for exactly one cycle per request. `busy` is high during that cycle and for max(tMRD,1) further cycles.
- R10: Any command sampled while `busy` is high is ignored.
- R11: Commands 000, 001, 010, 101, 110 and 111 change no register and raise neither `mrs_req` nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | User command |
| addr | input | ADDR_W | Address bus carrying register select and data |
| init_done | input | 1 | Power-up sequencer completion |
| burst_len | output | 3 | Burst length code |
| burst_ilv | output | 1 | Burst type, 1 = interleaved |
| cas_lat | output | 3 | CAS latency code |
| t_rcd | output | 3 | Activate-to-access delay |
| t_rrd | output | 3 | Activate-to-activate, different bank |
| t_rfc | output | 4 | Refresh command period |
| t_rp | output | 3 | Precharge period |
| t_mrd | output | 3 | Mode-register-set cycle time |
| t_wr | output | 3 | Write recovery |
| ref_interval | output | 16 | Refresh interval in cycles |
| t_ras | output | 4 | Activate-to-precharge |
| t_wtr | output | 3 | Write-to-read delay |
| t_rc | output | 4 | Activate-to-activate, same bank |
| drive_reduced | output | 1 | Reduced drive strength selected |
| qfc_enable | output | 1 | QFC function enabled |
| init_start | output | 1 | One-cycle initialization start |
| mrs_req | output | 1 | Mode-register-set request pulse |
| mrs_bank | output | 2 | Mode register selected by the request |
| mrs_value | output | 12 | Value to program |
| busy | output | 1 | New commands are not accepted |

## Verification
The bench builds the block with the default 22-bit address and the default reset vector. With those values every address bit has a meaning, and the power-on timing set is what the reset check sees. The 7-bit mode field is small enough to sweep all 128 register 0 settings, checking the fields and the request value for each. The 3-bit tMRD field allows every wait from 0 to 7 to be timed against the busy window, including the floor of one cycle at tMRD = 0.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int CFG_W  = 20;
  localparam int NCFG   = 4;
  localparam int MR_W   = 12;
  localparam int SEL_W  = $clog2(NCFG);
  localparam int TMRD_W = 3;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'b000,
    CMD_RD   = 3'b001,
    CMD_WR   = 3'b010,
    CMD_CFG  = 3'b011,
    CMD_MRS  = 3'b100,
    CMD_PDN  = 3'b101,
    CMD_SREF = 3'b110,
    CMD_RSV  = 3'b111
  } ucmd_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_e;

  // Bits of each configuration register that carry a defined field
  function automatic logic [CFG_W-1:0] cfg_mask(input int idx);
    case (idx)
      0:       return 20'h0007F;
      1:       return 20'h7FFFF;
      2:       return 20'h0FFFF;
      default: return 20'h007FF;
    endcase
  endfunction
endpackage

// File: rtl/cfgl_decode.sv
module cfgl_decode
  import cfgl_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic [2:0]             cmd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   busy,
  output logic [NCFG-1:0]        cfg_we,
  output logic [CFG_W-1:0]       cfg_wdata,
  output logic                   mr_we,
  output logic                   emr_we,
  output logic [MR_W-1:0]        mr_wdata
);
  logic accept;

  always_comb begin
    accept    = !busy;
    cfg_we    = '0;
    if (accept && cmd == CMD_CFG)
      cfg_we[addr[SEL_W-1:0]] = 1'b1;
    cfg_wdata = addr[CFG_W+1:2];
    mr_wdata  = addr[MR_W-1:0];
    mr_we     = accept && cmd == CMD_MRS && addr[13:12] == 2'b00;
    emr_we    = accept && cmd == CMD_MRS && addr[13:12] == 2'b01;
  end
endmodule

// File: rtl/cfgl_regs.sv
module cfgl_regs
  import cfgl_pkg::*;
#(
  parameter logic [NCFG-1:0][CFG_W-1:0] RST_CFG = '0,
  parameter logic [MR_W-1:0]            RST_EMR = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NCFG-1:0]              cfg_we,
  input  logic [CFG_W-1:0]             cfg_wdata,
  input  logic                         mr_we,
  input  logic                         emr_we,
  input  logic [MR_W-1:0]              mr_wdata,
  output logic [NCFG-1:0][CFG_W-1:0]   cfg_q,
  output logic                         emr_drive,
  output logic                         emr_qfc,
  output logic                         mrs_go,
  output logic [1:0]                   mrs_bank,
  output logic [MR_W-1:0]              mrs_val,
  output logic                         init_go
);
  logic [MR_W-8:0] mode_hi;  // mode register bits above the shared fields

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    localparam logic [CFG_W-1:0] MASK = cfg_mask(i);
    logic [CFG_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= RST_CFG[i] & MASK;
      else if (cfg_we[i])
        r <= cfg_wdata & MASK;
      else if (i == 0 && mr_we)
        r <= {r[CFG_W-1:7], mr_wdata[6:0]} & MASK;
    end
    assign cfg_q[i] = r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_hi   <= '0;
      emr_drive <= RST_EMR[1];
      emr_qfc   <= RST_EMR[2];
    end else begin
      if (mr_we)
        mode_hi <= mr_wdata[MR_W-1:7];
      if (emr_we) begin
        emr_drive <= mr_wdata[1];
        emr_qfc   <= mr_wdata[2];
      end
    end
  end

  always_comb begin
    mrs_go   = cfg_we[0] | mr_we | emr_we;
    mrs_bank = emr_we ? 2'b01 : 2'b00;
    mrs_val  = (mr_we || emr_we) ? mr_wdata : {mode_hi, cfg_wdata[6:0]};
    init_go  = cfg_we[0] & cfg_wdata[7];
  end

  // R11
  cfg0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we[0] && !mr_we) |=> $stable(cfg_q[0]));
endmodule

// File: rtl/cfgl_mrs_seq.sv
module cfgl_mrs_seq
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [1:0]        bank_in,
  input  logic [MR_W-1:0]   val_in,
  input  logic [TMRD_W-1:0] t_mrd,
  output logic              mrs_req,
  output logic [1:0]        mrs_bank,
  output logic [MR_W-1:0]   mrs_value,
  output logic              seq_busy
);
  seq_e              state;
  logic [TMRD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      mrs_req   <= 1'b0;
      mrs_bank  <= '0;
      mrs_value <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (go) begin
          state     <= SQ_REQ;
          mrs_req   <= 1'b1;
          mrs_bank  <= bank_in;
          mrs_value <= val_in;
          cnt       <= t_mrd;
        end
        SQ_REQ: begin
          mrs_req <= 1'b0;
          state   <= SQ_WAIT;
        end
        default: begin
          if (cnt <= 1) state <= SQ_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign seq_busy = (state != SQ_IDLE);

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_req |=> !mrs_req);
  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_req |-> seq_busy);
endmodule

// File: rtl/cfg_mode_loader.sv
module cfg_mode_loader
  import cfgl_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter logic [NCFG-1:0][CFG_W-1:0] RST_CFG =
    {20'h00416, 20'h008B4, 20'h24A52, 20'h00021},
  parameter logic [MR_W-1:0] RST_EMR = 12'h000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              init_done,
  output logic [2:0]        burst_len,
  output logic              burst_ilv,
  output logic [2:0]        cas_lat,
  output logic [2:0]        t_rcd,
  output logic [2:0]        t_rrd,
  output logic [3:0]        t_rfc,
  output logic [2:0]        t_rp,
  output logic [2:0]        t_mrd,
  output logic [2:0]        t_wr,
  output logic [15:0]       ref_interval,
  output logic [3:0]        t_ras,
  output logic [2:0]        t_wtr,
  output logic [3:0]        t_rc,
  output logic              drive_reduced,
  output logic              qfc_enable,
  output logic              init_start,
  output logic              mrs_req,
  output logic [1:0]        mrs_bank,
  output logic [11:0]       mrs_value,
  output logic              busy
);
  logic [NCFG-1:0]             cfg_we;
  logic [CFG_W-1:0]            cfg_wdata;
  logic                        mr_we, emr_we;
  logic [MR_W-1:0]             mr_wdata;
  logic [NCFG-1:0][CFG_W-1:0]  cfg_q;
  logic                        mrs_go, init_go, seq_busy, init_pend;
  logic [1:0]                  go_bank;
  logic [MR_W-1:0]             go_val;

  cfgl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cmd(cmd), .addr(addr), .busy(busy),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mr_we(mr_we), .emr_we(emr_we), .mr_wdata(mr_wdata));

  cfgl_regs #(.RST_CFG(RST_CFG), .RST_EMR(RST_EMR)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mr_we(mr_we), .emr_we(emr_we), .mr_wdata(mr_wdata),
    .cfg_q(cfg_q), .emr_drive(drive_reduced), .emr_qfc(qfc_enable),
    .mrs_go(mrs_go), .mrs_bank(go_bank), .mrs_val(go_val),
    .init_go(init_go));

  cfgl_mrs_seq u_seq (
    .clk(clk), .rst(rst), .go(mrs_go), .bank_in(go_bank),
    .val_in(go_val), .t_mrd(t_mrd), .mrs_req(mrs_req),
    .mrs_bank(mrs_bank), .mrs_value(mrs_value), .seq_busy(seq_busy));

  always_ff @(posedge clk) begin
    if (rst) begin
      init_start <= 1'b0;
      init_pend  <= 1'b0;
    end else begin
      init_start <= init_go;
      if (init_go)        init_pend <= 1'b1;
      else if (init_done) init_pend <= 1'b0;
    end
  end

  assign busy = seq_busy | init_pend;

  assign burst_len    = cfg_q[0][2:0];
  assign burst_ilv    = cfg_q[0][3];
  assign cas_lat      = cfg_q[0][6:4];
  assign t_rcd        = cfg_q[1][2:0];
  assign t_rrd        = cfg_q[1][5:3];
  assign t_rfc        = cfg_q[1][9:6];
  assign t_rp         = cfg_q[1][12:10];
  assign t_mrd        = cfg_q[1][15:13];
  assign t_wr         = cfg_q[1][18:16];
  assign ref_interval = cfg_q[2][15:0];
  assign t_ras        = cfg_q[3][3:0];
  assign t_wtr        = cfg_q[3][6:4];
  assign t_rc         = cfg_q[3][10:7];

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_q[0][19:7], cfg_q[1][19], cfg_q[2][19:16], cfg_q[3][19:11]};

  // R10
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mrs_req) |-> !$past(busy));
  // R5
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    init_start |=> !init_start);
  // R5
  init_busy_chk: assert property (@(posedge clk) disable iff (rst)
    init_start |-> busy);
endmodule

// File: tb/tb_cfg_mode_loader.sv
module tb_cfg_mode_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'b000;
  logic [21:0] addr = '0;
  logic        init_done = 1'b0;
  logic [2:0]  burst_len, cas_lat, t_rcd, t_rrd, t_rp, t_mrd, t_wr, t_wtr;
  logic        burst_ilv, drive_reduced, qfc_enable, init_start, mrs_req, busy;
  logic [3:0]  t_rfc, t_ras, t_rc;
  logic [15:0] ref_interval;
  logic [1:0]  mrs_bank;
  logic [11:0] mrs_value;

  int tests = 0;
  int fails = 0;
  logic [4:0] mode_hi_exp = '0;

  always #5 clk = ~clk;

  cfg_mode_loader dut (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .init_done(init_done),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
    .t_rcd(t_rcd), .t_rrd(t_rrd), .t_rfc(t_rfc), .t_rp(t_rp), .t_mrd(t_mrd),
    .t_wr(t_wr), .ref_interval(ref_interval), .t_ras(t_ras), .t_wtr(t_wtr),
    .t_rc(t_rc), .drive_reduced(drive_reduced), .qfc_enable(qfc_enable),
    .init_start(init_start), .mrs_req(mrs_req), .mrs_bank(mrs_bank),
    .mrs_value(mrs_value), .busy(busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [21:0] a);
    @(negedge clk);
    cmd = c; addr = a;
    @(negedge clk);
    cmd = 3'b000; addr = '0;
  endtask

  task automatic load_cfg(input logic [1:0] sel, input logic [19:0] d);
    issue(3'b011, {d, sel});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [31:0] pack_fields();
    return {burst_len, burst_ilv, cas_lat, t_rcd, t_rfc, ref_interval[11:0]};
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 bl", burst_len, 1);   check("R1 bt", burst_ilv, 0);
    check("R1 cl", cas_lat, 2);     check("R1 rcd", t_rcd, 2);
    check("R1 rrd", t_rrd, 2);      check("R1 rfc", t_rfc, 9);
    check("R1 rp", t_rp, 2);        check("R1 mrd", t_mrd, 2);
    check("R1 wr", t_wr, 2);        check("R1 ref", ref_interval, 2228);
    check("R1 ras", t_ras, 6);      check("R1 wtr", t_wtr, 1);
    check("R1 rc", t_rc, 8);        check("R1 busy", busy, 0);
    check("R1 req", mrs_req, 0);    check("R1 init", init_start, 0);
    check("R1 drv", drive_reduced, 0); check("R1 qfc", qfc_enable, 0);

    // R2 R3 loads of registers 1..3 with several patterns
    foreach (snap[k]) begin end
    for (int p = 0; p < 4; p++) begin
      logic [19:0] d;
      d = (p == 0) ? 20'hFFFFF : (p == 1) ? 20'h5A5A5 : (p == 2) ? 20'hA5A5A : 20'h00000;
      load_cfg(2'd1, d);
      check("R3 no req r1", mrs_req, 0); check("R3 no busy r1", busy, 0);
      check("R2 rcd", t_rcd, d[2:0]);   check("R2 rrd", t_rrd, d[5:3]);
      check("R2 rfc", t_rfc, d[9:6]);   check("R2 rp", t_rp, d[12:10]);
      check("R2 mrd", t_mrd, d[15:13]); check("R2 wr", t_wr, d[18:16]);
      load_cfg(2'd2, ~d);
      check("R3 no req r2", mrs_req, 0);
      check("R2 ref", ref_interval, 16'(~d));
      load_cfg(2'd3, d);
      check("R3 no busy r3", busy, 0);
      check("R2 ras", t_ras, d[3:0]); check("R2 wtr", t_wtr, d[6:4]);
      check("R2 rc", t_rc, d[10:7]);
    end

    // R4 exhaustive sweep of register 0 settings, tMRD = 1
    load_cfg(2'd1, 20'h02000);
    for (int v = 0; v < 128; v++) begin
      load_cfg(2'd0, 20'hFFF00 | 20'(v));
      check("R4 req", mrs_req, 1);       check("R4 bank", mrs_bank, 0);
      check("R4 value", mrs_value, {mode_hi_exp, 7'(v)});
      check("R4 bl", burst_len, v[2:0]); check("R4 bt", burst_ilv, v[3]);
      check("R4 cl", cas_lat, v[6:4]);
      wait_idle();
    end

    // R9 busy window against tMRD 0..7
    for (int t = 0; t < 8; t++) begin
      int n, reqs;
      load_cfg(2'd1, 20'(t) << 13);
      load_cfg(2'd0, 20'h00021);
      n = 0; reqs = 0;
      while (busy) begin
        n++; if (mrs_req) reqs++;
        @(negedge clk);
      end
      check("R9 busy cycles", n, 1 + ((t < 1) ? 1 : t));
      check("R9 one req", reqs, 1);
    end

    // R6 direct mode write copies fields back
    issue(3'b100, 22'h001A3);
    mode_hi_exp = 5'h03;
    check("R6 req", mrs_req, 1);   check("R6 bank", mrs_bank, 0);
    check("R6 value", mrs_value, 12'h1A3);
    check("R6 bl", burst_len, 3);  check("R6 bt", burst_ilv, 0);
    check("R6 cl", cas_lat, 2);
    wait_idle();
    load_cfg(2'd0, 20'h00052);
    check("R4 keeps upper bits", mrs_value, 12'h1D2);
    wait_idle();

    // R7 extended mode register
    issue(3'b100, 22'h01006);
    check("R7 bank", mrs_bank, 1); check("R7 value", mrs_value, 12'h006);
    check("R7 drv", drive_reduced, 1); check("R7 qfc", qfc_enable, 1);
    check("R7 fields kept", burst_len, 2);
    wait_idle();
    issue(3'b100, 22'h01002);
    check("R7 qfc off", qfc_enable, 0); check("R7 drv on", drive_reduced, 1);
    wait_idle();

    // R8 mode banks 2 and 3
    snap = pack_fields();
    for (int b = 2; b < 4; b++) begin
      issue(3'b100, (22'(b) << 12) | 22'h0FFF);
      check("R8 no req", mrs_req, 0); check("R8 no busy", busy, 0);
      check("R8 fields", pack_fields(), snap);
      check("R8 drv", drive_reduced, 1);
    end

    // R11 other commands ignored
    foreach (snap[k]) begin end
    for (int c = 0; c < 8; c++) begin
      if (c == 3 || c == 4) continue;
      issue(3'(c), 22'h3FFFFC);
      check("R11 no req", mrs_req, 0); check("R11 no busy", busy, 0);
      check("R11 fields", pack_fields(), snap);
    end

    // R10 commands while busy are ignored
    load_cfg(2'd1, 20'(5) << 13);
    load_cfg(2'd0, 20'h00013);
    @(negedge clk);
    cmd = 3'b011; addr = {20'h00031, 2'd0};
    @(negedge clk);
    cmd = 3'b011; addr = {20'h00123, 2'd2};
    @(negedge clk);
    cmd = 3'b000; addr = '0;
    wait_idle();
    @(negedge clk);
    check("R10 bl kept", burst_len, 3); check("R10 cl kept", cas_lat, 1);
    check("R10 ref kept", ref_interval, 16'(~20'h00000));
    check("R10 no second req", mrs_req, 0);

    // R5 init start and hold
    load_cfg(2'd0, 20'h000A1);
    check("R5 init pulse", init_start, 1);
    check("R5 busy", busy, 1);
    @(negedge clk);
    check("R5 pulse ends", init_start, 0);
    repeat (12) @(negedge clk);
    check("R5 still busy", busy, 1);
    check("R5 init bit not a field", cas_lat, 2);
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    check("R5 released", busy, 0);

    finish_run();
  end
endmodule